// File: doc/BRIEF.md
# Multi-Format Asynchronous Serial Transmitter

This block sends characters one at a time on a single serial output wire. The wire rests at logic 1. Each frame opens with a 0 start bit. The data bits follow, least significant bit first. An optional ninth bit may come next, and the frame closes with one or two stop bits at 1. A bit never returns to a neutral level between neighbours of equal value: the wire simply holds the bit's value for the whole bit period.

A 4-bit format code selects what follows the start bit:

- seven data bits;
- eight data bits;
- eight data bits plus an odd parity bit;
- eight data bits plus an even parity bit;
- eight data bits plus an address/data marker supplied with the character.

An external divider provides the bit timing as a single-cycle strobe. The frame advances by exactly one bit on each strobe.

Characters enter through a ready/valid port that holds one character. One character can therefore wait while the previous one is being shifted out. When a character is waiting as the last stop bit ends, its start bit follows on the very next strobe, with no idle gap. The format code and the stop-bit selection are read only when a frame is loaded. Changing them part-way through a frame has no effect on that frame.

Top module: `serial_tx_top`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `tx_line` is 1 and `wr_ready` is 1 while nothing is waiting.
- R2: A frame is a 0 start bit, then the data bits, then the optional ninth bit, then stop bits of 1. `tx_line` changes only in the clock cycle that follows a cycle in which `baud_tick` was 1, so each bit lasts exactly one tick interval.
- R3: Data bits leave least significant bit first.
- R4: Format code 4'b0000 sends `wr_data[7:0]` with no ninth bit. Format code 4'b0001 sends only `wr_data[6:0]`, with no ninth bit, and `wr_data[7]` never appears on the line.
- R5: Format code 4'b0010 adds a ninth bit that makes the count of ones over the 8 data bits plus the ninth bit odd. Format code 4'b0011 makes that count even.
- R6: Format code 4'b0100 sends 8 data bits, then a ninth bit equal to the `wr_addr_flag` value captured with that character (1 marks an address, 0 marks data).
- R7: A write is accepted in a cycle with `wr_valid` and `wr_ready` both 1. `wr_ready` is 0 from the next cycle while a character is waiting. A character written during a frame is sent after that frame.
- R8: `two_stop` = 0 gives one stop bit and `two_stop` = 1 gives two. If a character is waiting, its start bit begins on the tick right after the last stop bit.
- R9: Format codes other than 4'b0000 to 4'b0100 behave exactly as 4'b0000.
- R10: `mode_sel` and `two_stop` are sampled when a frame is loaded. A change during a frame alters only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| mode_sel | input | 4 | Frame format code |
| two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| wr_valid | input | 1 | Character offered |
| wr_data | input | 8 | Character data |
| wr_addr_flag | input | 1 | Ninth-bit marker for the address format |
| wr_ready | output | 1 | Holding slot is empty |
| tx_line | output | 1 | Serial output, idles at 1 |

## Verification
The properties assume the following about the inputs:

- `baud_tick` is a one-cycle strobe.
- A write offered with `wr_valid` holds its data until it is accepted.
- Reset is asserted before any strobe arrives.

The bench meets these assumptions directly. It raises the strobe for one cycle in every four. It offers each character for exactly one cycle, and only once `wr_ready` is seen high. It changes the format code and the stop selection mid-frame only in the one sequence built to show that the change has no effect on the frame already in progress.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DW = 8;              // widest data field
    localparam int MAX_STOP = 2;        // most stop bits in a frame
    localparam int FW = 1 + DW + 1 + MAX_STOP;  // start + data + ninth + stops
    localparam int CW = $clog2(FW + 1);

    typedef enum logic [3:0] {
        FMT_8N = 4'b0000,
        FMT_7N = 4'b0001,
        FMT_8O = 4'b0010,
        FMT_8E = 4'b0011,
        FMT_9A = 4'b0100
    } fmt_e;

    typedef struct packed {
        logic [FW-1:0] bits;   // bit 0 leaves first
        logic [CW-1:0] len;    // bits in this frame
    } frame_t;

    typedef struct packed {
        logic          full;
        logic [DW-1:0] data;
        logic          flag;
    } slot_t;

    typedef struct packed {
        logic          active;
        logic          line;
        logic [CW-1:0] left;
        logic [FW-1:0] sh;
    } shift_t;

endpackage

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_flag,
    input  logic          pop,
    output logic          wr_ready,
    output logic          full,
    output logic [DW-1:0] data,
    output logic          flag
);

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (pop) begin
            slot_d.full = 1'b0;
        end
        if (wr_valid && !slot_q.full) begin
            slot_d.full = 1'b1;
            slot_d.data = wr_data;
            slot_d.flag = wr_flag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '{full: 1'b0, data: '0, flag: 1'b0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign wr_ready = !slot_q.full;
    assign full     = slot_q.full;
    assign data     = slot_q.data;
    assign flag     = slot_q.flag;

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic          addr_flag,
    input  logic [3:0]    mode,
    input  logic          two_stop,
    output frame_t        frame
);

    logic          seven;
    logic          ninth_en;
    logic          ninth;
    logic [CW-1:0] n_data;
    logic [CW-1:0] n_stop;

    always_comb begin
        seven    = 1'b0;
        ninth_en = 1'b0;
        ninth    = 1'b1;
        unique case (mode)
            FMT_7N: seven = 1'b1;
            FMT_8O: begin
                ninth_en = 1'b1;
                ninth    = ~(^data);
            end
            FMT_8E: begin
                ninth_en = 1'b1;
                ninth    = ^data;
            end
            FMT_9A: begin
                ninth_en = 1'b1;
                ninth    = addr_flag;
            end
            default: ;
        endcase
    end

    always_comb begin
        frame.bits        = '1;
        frame.bits[0]     = 1'b0;
        frame.bits[DW:1]  = data;
        if (seven) begin
            frame.bits[DW] = 1'b1;
        end
        if (ninth_en) begin
            frame.bits[DW+1] = ninth;
        end
        n_data    = seven ? CW'(DW - 1) : CW'(DW);
        n_stop    = two_stop ? CW'(2) : CW'(1);
        frame.len = CW'(1) + n_data + CW'(ninth_en) + n_stop;
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          have_char,
    input  frame_t        frame_in,
    output logic          pop,
    output logic          line,
    output logic          active,
    output logic [CW-1:0] bits_left
);

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (tick) begin
            if (st_q.active && st_q.left > CW'(1)) begin
                st_d.sh   = {1'b1, st_q.sh[FW-1:1]};
                st_d.left = st_q.left - CW'(1);
            end else if (have_char) begin
                st_d.sh     = frame_in.bits;
                st_d.left   = frame_in.len;
                st_d.active = 1'b1;
                pop         = 1'b1;
            end else begin
                st_d.sh     = '1;
                st_d.left   = '0;
                st_d.active = 1'b0;
            end
        end
        st_d.line = st_d.active ? st_d.sh[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, line: 1'b1, left: '0, sh: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign line      = st_q.line;
    assign active    = st_q.active;
    assign bits_left = st_q.left;

endmodule

// File: rtl/serial_tx_top.sv
module serial_tx_top
    import sertx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        baud_tick,
    input  logic [3:0]  mode_sel,
    input  logic        two_stop,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        wr_addr_flag,
    output logic        wr_ready,
    output logic        tx_line
);

    logic          slot_full;
    logic [DW-1:0] slot_data;
    logic          slot_flag;
    logic          slot_pop;
    frame_t        next_frame;
    logic          sh_active;
    logic [CW-1:0] sh_left;

    sertx_holdbuf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_flag  (wr_addr_flag),
        .pop      (slot_pop),
        .wr_ready (wr_ready),
        .full     (slot_full),
        .data     (slot_data),
        .flag     (slot_flag)
    );

    sertx_framer u_frm (
        .data      (slot_data),
        .addr_flag (slot_flag),
        .mode      (mode_sel),
        .two_stop  (two_stop),
        .frame     (next_frame)
    );

    sertx_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .have_char (slot_full),
        .frame_in  (next_frame),
        .pop       (slot_pop),
        .line      (tx_line),
        .active    (sh_active),
        .bits_left (sh_left)
    );

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
    import sertx_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          baud_tick,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          tx_line,
    input logic          active,
    input logic [CW-1:0] bits_left
);

    // R1: the wire rests at mark whenever no frame runs
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> tx_line);

    // R2: the wire moves only after a tick
    a_r2_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_line));

    // R2: a new frame opens with a space
    a_r2_start_space: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> !tx_line);

    // R8: the final bit of any frame is a stop bit
    a_r8_last_is_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bits_left == CW'(1)) |-> tx_line);

    // R7: an accepted write occupies the slot
    a_r7_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> !wr_ready);

endmodule

bind serial_tx_top sertx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .tx_line   (tx_line),
    .active    (sh_active),
    .bits_left (sh_left)
);

// File: tb/sim_serial_tx_top.sv
module sim_serial_tx_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [3:0] mode_sel = 4'd0;
    logic       two_stop = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_addr_flag = 1'b0;
    logic       wr_ready;
    logic       tx_line;

    serial_tx_top u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode_sel(mode_sel),
        .two_stop(two_stop), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_addr_flag(wr_addr_flag), .wr_ready(wr_ready), .tx_line(tx_line)
    );

    always #5 clk = ~clk;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    bit   rec_en = 1'b0;
    int   tdiv = 0;
    int   hptr = 0;
    int   r2_bad = 0;
    logic hist [0:4095];

    logic [7:0] exp_d [0:63];
    logic       exp_f [0:63];
    logic [3:0] exp_m [0:63];
    logic       exp_s [0:63];
    int         nexp = 0;

    task automatic chk(input bit ok, input string req, input int got, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, expv);
        end
    endtask

    // tick generator and per-bit recorder, both at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rec_en) begin
                if (baud_tick) begin
                    hist[hptr] = tx_line;
                    hptr++;
                end else if (hptr > 0 && tx_line !== hist[hptr-1]) begin
                    r2_bad++;
                end
            end
            tdiv = (tdiv == 3) ? 0 : tdiv + 1;
            baud_tick = (tdiv == 0);
        end
    end

    task automatic send(input logic [7:0] d, input logic f);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_data = d;
        wr_addr_flag = f;
        wr_valid = 1'b1;
        exp_d[nexp] = d;
        exp_f[nexp] = f;
        exp_m[nexp] = mode_sel;
        exp_s[nexp] = two_stop;
        nexp++;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic begin_batch();
        hptr = 0;
        nexp = 0;
        r2_bad = 0;
        rec_en = 1'b1;
    endtask

    task automatic drain_and_decode();
        int p;
        int gap;
        int nd;
        int ns;
        logic [7:0] got;
        logic [7:0] want;
        logic g9;
        logic w9;
        string tag;
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        repeat (15 * 4 + 8) @(negedge clk);
        rec_en = 1'b0;
        chk(r2_bad == 0, "R2 line stable between ticks", r2_bad, 0);
        p = 0;
        for (int i = 0; i < nexp; i++) begin
            gap = 0;
            while (p < hptr && hist[p] === 1'b1) begin
                p++;
                gap++;
            end
            if (i > 0) chk(gap == 0, "R8 back-to-back start", gap, 0);
            chk(p < hptr, "R2 start bit present", p, hptr);
            p++;
            nd = (exp_m[i] == 4'd1) ? 7 : 8;
            ns = exp_s[i] ? 2 : 1;
            got = 8'h00;
            for (int b = 0; b < nd; b++) begin
                got[b] = hist[p];
                p++;
            end
            want = (nd == 7) ? {1'b0, exp_d[i][6:0]} : exp_d[i];
            tag = (exp_m[i] > 4'd4) ? "R9 undefined code as 8-bit"
                : "R3 R4 data bits lsb first";
            chk(got === want, tag, int'(got), int'(want));
            if (exp_m[i] >= 4'd2 && exp_m[i] <= 4'd4) begin
                g9 = hist[p];
                p++;
                if (exp_m[i] == 4'd2) begin
                    w9 = ($countones(exp_d[i]) % 2 == 0);
                    chk(g9 === w9, "R5 odd parity", int'(g9), int'(w9));
                end else if (exp_m[i] == 4'd3) begin
                    w9 = ($countones(exp_d[i]) % 2 == 1);
                    chk(g9 === w9, "R5 even parity", int'(g9), int'(w9));
                end else begin
                    w9 = exp_f[i];
                    chk(g9 === w9, "R6 address flag", int'(g9), int'(w9));
                end
            end
            for (int k = 0; k < ns; k++) begin
                chk(hist[p] === 1'b1, "R8 stop bit", int'(hist[p]), 1);
                p++;
            end
        end
    endtask

    initial begin
        logic [3:0] mlist [0:7];
        mlist[0] = 4'd0; mlist[1] = 4'd1; mlist[2] = 4'd2; mlist[3] = 4'd3;
        mlist[4] = 4'd4; mlist[5] = 4'd5; mlist[6] = 4'd9; mlist[7] = 4'd15;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(tx_line === 1'b1, "R1 idle line in reset", int'(tx_line), 1);
        chk(wr_ready === 1'b1, "R1 ready in reset", int'(wr_ready), 1);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(tx_line === 1'b1, "R1 idle line after reset", int'(tx_line), 1);

        // R7: one character waits behind the one in flight
        mode_sel = 4'd0;
        two_stop = 1'b0;
        begin_batch();
        send(8'h3C, 1'b0);
        send(8'hC3, 1'b0);
        chk(wr_ready === 1'b0, "R7 slot full while frame runs", int'(wr_ready), 0);
        drain_and_decode();
        chk(nexp == 2, "R7 both characters sent", nexp, 2);

        // sweep of formats, stop counts and character values
        for (int mi = 0; mi < 8; mi++) begin
            for (int s = 0; s < 2; s++) begin
                mode_sel = mlist[mi];
                two_stop = s[0];
                begin_batch();
                for (int i = 0; i < 20; i++) begin
                    logic [7:0] d;
                    if (i == 0) d = 8'h00;
                    else if (i == 1) d = 8'hFF;
                    else if (i < 10) d = 8'h01 << (i - 2);
                    else d = 8'(i * 37 + mi * 11 + s * 5);
                    send(d, i[0]);
                end
                drain_and_decode();
            end
        end

        // R10: format and stop count change in mid-frame
        mode_sel = 4'd0;
        two_stop = 1'b0;
        begin_batch();
        send(8'hB6, 1'b1);
        while (tx_line !== 1'b0) @(negedge clk);
        repeat (6) @(negedge clk);
        mode_sel = 4'd3;
        two_stop = 1'b1;
        send(8'h4D, 1'b0);
        drain_and_decode();
        chk(exp_m[0] == 4'd0 && exp_m[1] == 4'd3, "R10 format per frame",
            int'(exp_m[1]), 3);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule